// File: doc/BRIEF.md
# Debug Breakpoint Qualifier

This block sits between the address/data comparators of a processor core and the core's debug-exception request line. Every cycle it receives raw match pulses from instruction comparators, load/store comparators and watchpoint comparators. It decides which of them become a breakpoint request, which advance the programmable debug counters, and which are forwarded to the external watchpoint outputs.

Qualification depends on two things. The first is a mode bit that selects masked or non-masked operation. The second is the core's recoverable-interrupt status bit. In masked mode a breakpoint can only be taken while the core is able to recover from an exception. In non-masked mode breakpoints are always taken, and taking one while recovery is impossible leaves a sticky non-restartable flag.

Instruction breakpoints also support a skip-once option. After an enable event, the first qualified instruction match is swallowed, so that a debugger can resume execution from the address it stopped at. Control and counter registers are loaded through a plain write strobe with an address and a data word.

Top module: `dbg_bkpt_qual`

## Requirements
- R1: After synchronous reset the unit is in masked mode, every comparator enable is 0, every counter is 0, the skip flag is clear, and `bp_req_o`, `bp_cause_o`, `wp_out_o` and `nonrestart_o` are all 0.
- R2: In masked mode (mode bit 0), an instruction or load/store match seen while `recov_i` is 0 produces no request. It is not held and not replayed when `recov_i` later returns to 1.
- R3: Writing address 0 with data bit 0 set selects non-masked mode. In non-masked mode, enabled instruction and load/store matches raise a request whatever the value of `recov_i`.
- R4: Address 0 data bits [NL:1] enable the load/store comparators. Address 1 data bits [NI:1] enable the instruction comparators. A match on a disabled comparator produces no request.
- R5: `wp_out_o` equals the `wpmatch_i` vector of the previous cycle, in every mode and for either value of `recov_i`.
- R6: Writing address 2+k loads debug counter k with data bits [CW-1:0]. A load in the same cycle as a watchpoint wins over the decrement. Counter k decrements on each qualified watchpoint k, meaning `wpmatch_i[k]` while non-masked or while `recov_i` is 1. The decrement that takes it from 1 to 0 raises a request. A counter at 0 stays at 0 and raises nothing.
- R7: `nonrestart_o` is set when a request is issued in non-masked mode while `recov_i` is 0. It stays at 1 until reset.
- R8: Address 1 data bit 0 is the skip-once bit. The first write to address 1 after reset is an enable event, and later writes are not. An enable event taken with the skip-once bit set suppresses the next qualified instruction match, including one in the same cycle. Matches after that fire normally.
- R9: In masked mode only, a 0-to-1 transition of `recov_i` is also an enable event and re-arms the skip when the stored skip-once bit is 1. In non-masked mode such a transition re-arms nothing.
- R10: A request is a pulse on `bp_req_o` in the cycle after the qualifying match. `bp_cause_o` bit 0 marks instruction, bit 1 marks load/store and bit 2 marks counter expiry, and these bits are nonzero exactly when `bp_req_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address: 0 mode and load/store enables, 1 instruction control, 2+k counter k |
| wr_data | input | CW | Register write data |
| recov_i | input | 1 | Core recoverable-interrupt status |
| imatch_i | input | NI | Raw instruction comparator matches |
| lsmatch_i | input | NL | Raw load/store comparator matches |
| wpmatch_i | input | NW | Raw watchpoint matches |
| bp_req_o | output | 1 | Breakpoint request pulse |
| bp_cause_o | output | 3 | Request cause: bit 2 counter, bit 1 load/store, bit 0 instruction |
| wp_out_o | output | NW | Watchpoints forwarded to external pins |
| nonrestart_o | output | 1 | Sticky non-restartable status |

## Verification
The assertions assume that `recov_i` and the match vectors are clean synchronous levels sampled once per clock. They also assume that the mode bit is changed only by a register write, so the mode visible in a cycle is the one used to qualify that cycle's matches. The stimulus drives every input at the falling edge and writes registers through the strobe alone, which keeps it inside these assumptions. Random traffic keeps `recov_i` high most of the time, so the skip, counter-expiry and mode-flip paths all occur, while directed steps cover the enable-event edges.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  localparam int NCAUSE = 3;

  typedef struct packed {
    logic cnt;
    logic ls;
    logic instr;
  } cause_t;
endpackage

// File: rtl/dbg_bkpt_regs.sv
module dbg_bkpt_regs #(
  parameter int NI = 4,
  parameter int NL = 2,
  parameter int AW = 2,
  localparam int RW = 1 + ((NI > NL) ? NI : NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  input  logic          recov,
  input  logic          ihit,
  output logic          nomask,
  output logic [NL-1:0] ls_en,
  output logic [NI-1:0] i_en,
  output logic          skip_eff
);
  logic ifm, seen, recov_q, skip;
  logic wr_mode, wr_ictl, first_ev, rise_ev;

  assign wr_mode  = wr_en && (wr_addr == AW'(0));
  assign wr_ictl  = wr_en && (wr_addr == AW'(1));
  assign first_ev = wr_ictl && !seen;
  assign rise_ev  = recov && !recov_q && !nomask;
  // Skip as seen by this cycle's match: an enable event arms it at once.
  assign skip_eff = skip | (first_ev & wr_data[0]) | (rise_ev & ifm);

  always_ff @(posedge clk) begin
    if (rst) begin
      nomask  <= 1'b0;
      ls_en   <= '0;
      i_en    <= '0;
      ifm     <= 1'b0;
      seen    <= 1'b0;
      recov_q <= 1'b1;
      skip    <= 1'b0;
    end else begin
      recov_q <= recov;
      skip    <= ihit ? 1'b0 : skip_eff;
      if (wr_mode) begin
        nomask <= wr_data[0];
        ls_en  <= wr_data[1 +: NL];
      end
      if (wr_ictl) begin
        ifm  <= wr_data[0];
        i_en <= wr_data[1 +: NI];
        seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbg_bkpt_cnt.sv
module dbg_bkpt_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          expire
);
  logic [CW-1:0] cnt;

  assign expire = tick && !load && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/dbg_bkpt_qual.sv
module dbg_bkpt_qual
  import dbg_bkpt_pkg::*;
#(
  parameter int NI   = 4,
  parameter int NL   = 2,
  parameter int NW   = 4,
  parameter int NCNT = 2,
  parameter int CW   = 16,
  localparam int AW  = $clog2(NCNT + 2),
  localparam int RW  = 1 + ((NI > NL) ? NI : NL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              recov_i,
  input  logic [NI-1:0]     imatch_i,
  input  logic [NL-1:0]     lsmatch_i,
  input  logic [NW-1:0]     wpmatch_i,
  output logic              bp_req_o,
  output logic [NCAUSE-1:0] bp_cause_o,
  output logic [NW-1:0]     wp_out_o,
  output logic              nonrestart_o
);
  logic          nomask, skip_eff, rec_ok, ihit, ifire, lfire, cfire;
  logic [NL-1:0] ls_en;
  logic [NI-1:0] i_en;
  logic [NCNT-1:0] expire;
  cause_t        cause_n, cause_q;

  assign rec_ok = nomask | recov_i;
  assign ihit   = (|(imatch_i & i_en)) & rec_ok;
  assign ifire  = ihit & ~skip_eff;
  assign lfire  = (|(lsmatch_i & ls_en)) & rec_ok;

  dbg_bkpt_regs #(.NI(NI), .NL(NL), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data[RW-1:0]), .recov(recov_i), .ihit(ihit),
    .nomask(nomask), .ls_en(ls_en), .i_en(i_en), .skip_eff(skip_eff)
  );

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    dbg_bkpt_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst),
      .load(wr_en && (wr_addr == AW'(k + 2))),
      .load_val(wr_data),
      .tick(wpmatch_i[k] & rec_ok),
      .expire(expire[k])
    );
  end

  assign cfire = |expire;

  always_comb begin
    cause_n.cnt   = cfire;
    cause_n.ls    = lfire;
    cause_n.instr = ifire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q      <= '0;
      bp_req_o     <= 1'b0;
      wp_out_o     <= '0;
      nonrestart_o <= 1'b0;
    end else begin
      cause_q      <= cause_n;
      bp_req_o     <= |cause_n;
      wp_out_o     <= wpmatch_i;
      nonrestart_o <= nonrestart_o | (nomask & ~recov_i & (|cause_n));
    end
  end

  assign bp_cause_o = cause_q;
endmodule

// File: rtl/dbg_bkpt_chk.sv
module dbg_bkpt_chk #(
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          recov,
  input logic          nomask,
  input logic [NW-1:0] wp_in,
  input logic [NW-1:0] wp_out,
  input logic          bp_req,
  input logic          nonrestart
);
  // R5: forwarded watchpoints follow the raw inputs by one cycle
  a_r5_wp_mirror: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (wp_out == $past(wp_in)));

  // R2: masked mode with recovery blocked never yields a request
  a_r2_masked_drop: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!nomask && !recov)) |-> !bp_req);

  // R7: non-restartable status never clears outside reset
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    nonrestart |=> nonrestart);

  // R7: a request taken unmasked with recovery blocked sets the flag
  a_r7_set: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && bp_req && $past(nomask && !recov)) |-> nonrestart);
endmodule

bind dbg_bkpt_qual dbg_bkpt_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst(rst), .recov(recov_i), .nomask(nomask),
  .wp_in(wpmatch_i), .wp_out(wp_out_o), .bp_req(bp_req_o),
  .nonrestart(nonrestart_o)
);

// File: tb/dbg_bkpt_qual_tb.sv
module dbg_bkpt_qual_tb_top;
  localparam int NI = 4, NL = 2, NW = 4, NCNT = 2, CW = 16, AW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, recov_i = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NI-1:0] imatch_i = '0;
  logic [NL-1:0] lsmatch_i = '0;
  logic [NW-1:0] wpmatch_i = '0;
  logic bp_req_o, nonrestart_o;
  logic [2:0] bp_cause_o;
  logic [NW-1:0] wp_out_o;

  int checks = 0, errs = 0;

  always #10 clk = ~clk;

  dbg_bkpt_qual #(.NI(NI), .NL(NL), .NW(NW), .NCNT(NCNT), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .recov_i(recov_i), .imatch_i(imatch_i), .lsmatch_i(lsmatch_i),
    .wpmatch_i(wpmatch_i), .bp_req_o(bp_req_o), .bp_cause_o(bp_cause_o),
    .wp_out_o(wp_out_o), .nonrestart_o(nonrestart_o)
  );

  // behavioural model of the requirements
  logic m_nm, m_ifm, m_seen, m_rq, m_skip, m_nr;
  logic [NL-1:0] m_lse;
  logic [NI-1:0] m_ien;
  logic [CW-1:0] m_cnt [NCNT];

  task automatic model_reset();
    m_nm = 0; m_ifm = 0; m_seen = 0; m_rq = 1; m_skip = 0; m_nr = 0;
    m_lse = '0; m_ien = '0;
    for (int k = 0; k < NCNT; k++) m_cnt[k] = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; imatch_i = '0; lsmatch_i = '0; wpmatch_i = '0;
    recov_i = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic tick(input logic [NI-1:0] im, input logic [NL-1:0] lm,
                      input logic [NW-1:0] wp, input logic rc, input logic we,
                      input logic [AW-1:0] wa, input logic [CW-1:0] wd,
                      input string tag);
    logic ok, wev, rise, se, ih, ef, lf, cf, tk, ld, nr_n;
    logic [2:0] ecause;
    ok   = m_nm | rc;
    wev  = we && wa == 1 && !m_seen;
    rise = rc && !m_rq && !m_nm;
    se   = m_skip | (wev & wd[0]) | (rise & m_ifm);
    ih   = (|(im & m_ien)) && ok;
    ef   = ih && !se;
    lf   = (|(lm & m_lse)) && ok;
    cf   = 0;
    for (int k = 0; k < NCNT; k++) begin
      tk = wp[k] && ok;
      ld = we && wa == AW'(k + 2);
      if (ld) m_cnt[k] = wd;
      else if (tk && m_cnt[k] != 0) begin
        if (m_cnt[k] == 1) cf = 1;
        m_cnt[k] = m_cnt[k] - 1;
      end
    end
    ecause = {cf, lf, ef};
    nr_n = m_nr | (m_nm && !rc && (|ecause));
    m_skip = ih ? 1'b0 : se;
    m_rq = rc;
    if (we && wa == 0) begin m_nm = wd[0]; m_lse = wd[1 +: NL]; end
    if (we && wa == 1) begin m_ifm = wd[0]; m_ien = wd[1 +: NI]; m_seen = 1; end
    m_nr = nr_n;
    imatch_i = im; lsmatch_i = lm; wpmatch_i = wp; recov_i = rc;
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(negedge clk);
    checks++;
    if (bp_req_o !== (|ecause) || bp_cause_o !== ecause ||
        wp_out_o !== wp || nonrestart_o !== nr_n) begin
      errs++;
      $display("FAIL %s: req=%b cause=%b wp=%h nr=%b expected req=%b cause=%b wp=%h nr=%b",
               tag, bp_req_o, bp_cause_o, wp_out_o, nonrestart_o,
               |ecause, ecause, wp, nr_n);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    tick(0, 0, 0, 1, 0, 0, 0, "R1");
    tick(0, 0, 0, 1, 1, 0, 16'h06, "R4");
    tick(0, 0, 0, 1, 1, 1, 16'h1F, "R8");
    tick(1, 0, 0, 0, 0, 0, 0, "R2");
    tick(1, 0, 0, 1, 0, 0, 0, "R8");
    tick(1, 0, 0, 1, 0, 0, 0, "R10");
    tick(0, 0, 0, 1, 0, 0, 0, "R10");
    tick(0, 1, 0, 1, 0, 0, 0, "R4");
    tick(0, 2, 0, 0, 0, 0, 0, "R2");
    tick(0, 0, 0, 0, 0, 0, 0, "R9");
    tick(1, 0, 0, 1, 0, 0, 0, "R9");
    tick(1, 0, 0, 1, 0, 0, 0, "R9");
    tick(0, 0, 0, 1, 1, 1, 16'h1F, "R8");
    tick(1, 0, 0, 1, 0, 0, 0, "R8");
    tick(0, 0, 0, 1, 1, 2, 16'h02, "R6");
    tick(0, 0, 1, 0, 0, 0, 0, "R5");
    tick(0, 0, 1, 1, 0, 0, 0, "R6");
    tick(0, 0, 1, 1, 0, 0, 0, "R6");
    tick(0, 0, 1, 1, 0, 0, 0, "R6");
    tick(0, 0, 0, 1, 1, 0, 16'h07, "R3");
    tick(1, 0, 0, 0, 0, 0, 0, "R3");
    tick(0, 0, 0, 1, 0, 0, 0, "R7");
    tick(0, 0, 0, 0, 0, 0, 0, "R9");
    tick(1, 0, 0, 1, 0, 0, 0, "R9");
    tick(0, 0, 0, 1, 1, 1, 16'h01, "R4");
    tick(1, 0, 0, 1, 0, 0, 0, "R4");
    tick(0, 0, 4'hF, 0, 0, 0, 0, "R5");

    do_reset();
    tick(0, 0, 0, 1, 0, 0, 0, "R1");
    for (int i = 0; i < 3000; i++) begin
      tick(NI'($urandom & 32'hF & ((($urandom % 3) == 0) ? 32'hF : 32'h0)),
           NL'($urandom), NW'($urandom),
           ($urandom % 4) != 0,
           ($urandom % 8) == 0, AW'($urandom), CW'($urandom & 32'h3F),
           "random R2 R3 R6 R8 R9");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule